// File: doc/BRIEF.md
# Float-to-Integer Saturating Converter

This block turns a single-precision IEEE-754 operand into an integer result in one combinational step. Two select inputs choose the destination type: signed or unsigned, and 32-bit (narrow) or 64-bit (wide). Rounding always truncates toward zero, so any fraction is dropped.

A narrow result always sits in the 64-bit destination as a sign-extended 32-bit value. This holds for unsigned narrow conversions too: a narrow unsigned result with bit 31 set fills the upper half with ones.

NaN operands, infinities and finite values that do not fit the chosen type never wrap. They give a fixed saturation value and raise the invalid flag. An integer datapath uses the block for its float-to-integer conversion instructions. It writes `result` to the destination register and ORs `invalid` into its accumulated exception flags.

Top module: `f2i_conv`

## Requirements
- R1: An in-range finite operand gives its value truncated toward zero (for example 2.75 gives 2 and -2.75 gives -2), with `invalid` low.
- R2: Any operand with magnitude below 1.0 gives 0 with `invalid` low, for every type selection. This covers +0, -0, subnormals, and negative fractions under an unsigned selection.
- R3: A signed conversion of a finite operand at or above 2^31 (narrow) or 2^63 (wide) gives the type maximum (0x000000007FFFFFFF or 0x7FFFFFFFFFFFFFFF) with `invalid` high.
- R4: A signed conversion of an operand below the type minimum gives the minimum (0xFFFFFFFF80000000 narrow, 0x8000000000000000 wide) with `invalid` high. An operand exactly equal to -2^31 or -2^63 converts with `invalid` low.
- R5: A NaN (quiet or signalling, either sign) under a signed selection gives the positive maximum of the selected width with `invalid` high.
- R6: An unsigned conversion of a negative operand with magnitude 1.0 or more, including negative infinity, gives 0 with `invalid` high.
- R7: An unsigned conversion of a NaN, or of a positive operand at or above 2^32 (narrow) or 2^64 (wide), gives all 64 bits set with `invalid` high.
- R8: With `is_narrow`=1, bits 63..32 of `result` equal bit 31, whether the conversion is signed or unsigned.
- R9: Infinities follow the out-of-range rules of their sign: +inf gives the type maximum and -inf gives the signed minimum or unsigned 0, always with `invalid` high.
- R10: Wide conversions (`is_narrow`=0) place operands with exponents above the significand width by left shift. This gives exact results up to the type limit, for example 2^62 signed and 2^63 unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_bits | input | 32 | Single-precision operand: sign in bit 31, biased exponent in bits 30..23, fraction in bits 22..0 |
| is_unsigned | input | 1 | 1 selects an unsigned destination, 0 a signed one |
| is_narrow | input | 1 | 1 selects a 32-bit destination (sign-extended), 0 a 64-bit one |
| result | output | 64 | Converted or saturated integer |
| invalid | output | 1 | High when the operand is NaN or does not fit the selected type |

## Verification
The bench builds the block with its default parameters: an 8-bit exponent, a 23-bit fraction, a 64-bit destination and a 32-bit narrow width. These values reach every path the document defines.

Both shift directions are exercised: right shift below exponent 23 and left shift up to exponent 63. The wide width makes the exact boundary operands reachable: ±2^31, ±2^63, 2^32 and 2^64. Single-precision spacing near the boundaries also allows neighbours just inside and just outside each limit, such as 0x4EFFFFFF against 0x4F000000.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // Destination type, encoded as {narrow, unsigned}
  typedef enum logic [1:0] {
    CVT_S_WIDE   = 2'b00,
    CVT_U_WIDE   = 2'b01,
    CVT_S_NARROW = 2'b10,
    CVT_U_NARROW = 2'b11
  } cvt_kind_e;

  function automatic logic kind_unsigned(cvt_kind_e k);
    return k[0];
  endfunction

  function automatic logic kind_narrow(cvt_kind_e k);
    return k[1];
  endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FP_W = 1 + EXP_W + MAN_W,
  localparam int UE_W = EXP_W + 2
) (
  input  logic [FP_W-1:0]        op_bits,
  output logic                   op_sign,
  output logic signed [UE_W-1:0] exp_unb,
  output logic [MAN_W:0]         sig,
  output logic                   evt_nan,
  output logic                   evt_inf
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0] exp_field;
  logic [MAN_W-1:0] frac_field;

  function automatic logic signed [UE_W-1:0] unbias(logic [EXP_W-1:0] e);
    return $signed({2'b00, e}) - UE_W'(BIAS);
  endfunction

  always_comb begin
    op_sign    = op_bits[FP_W-1];
    exp_field  = op_bits[FP_W-2:MAN_W];
    frac_field = op_bits[MAN_W-1:0];
    exp_unb    = unbias(exp_field);
    sig        = {(exp_field != '0), frac_field};
    evt_nan    = (&exp_field) && (frac_field != '0);
    evt_inf    = (&exp_field) && (frac_field == '0);
  end
endmodule

// File: rtl/f2i_mag_shift.sv
module f2i_mag_shift #(
  parameter int MAN_W = 23,
  parameter int EXP_W = 8,
  parameter int XLEN  = 64,
  localparam int UE_W = EXP_W + 2
) (
  input  logic [MAN_W:0]         sig,
  input  logic signed [UE_W-1:0] exp_unb,
  output logic [XLEN-1:0]        mag,
  output logic                   evt_tiny,
  output logic                   evt_huge
);
  // Integer part of sig * 2^(exp_unb - MAN_W), valid for 0 <= exp_unb < XLEN
  function automatic logic [XLEN-1:0] trunc_mag(logic [MAN_W:0] s, int e);
    logic [XLEN-1:0] wide;
    wide = {{(XLEN-MAN_W-1){1'b0}}, s};
    if (e <= MAN_W) return wide >> (MAN_W - e);
    else            return wide << (e - MAN_W);
  endfunction

  int e_int;

  always_comb begin
    e_int    = int'(exp_unb);
    evt_tiny = (e_int < 0);
    evt_huge = (e_int >= XLEN);
    if (evt_tiny || evt_huge) mag = '0;
    else                      mag = trunc_mag(sig, e_int);
  end
endmodule

// File: rtl/f2i_sat_sel.sv
module f2i_sat_sel
  import f2i_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32
) (
  input  cvt_kind_e       kind,
  input  logic            op_sign,
  input  logic            evt_nan,
  input  logic            evt_huge,
  input  logic [XLEN-1:0] mag,
  output logic            sat_hit,
  output logic [XLEN-1:0] sat_val
);
  localparam int HI_W = XLEN - NARROW_W;
  localparam logic [XLEN-1:0] W_SMAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] W_SMIN = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] N_SMAX = {{(HI_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic [XLEN-1:0] N_SMIN = {{(HI_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};
  localparam logic [XLEN-1:0] N_UMAX = {{HI_W{1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [XLEN-1:0] ALL1   = {XLEN{1'b1}};

  // Largest magnitude a positive operand may have
  function automatic logic [XLEN-1:0] pos_limit(cvt_kind_e k);
    case (k)
      CVT_S_WIDE:   return W_SMAX;
      CVT_S_NARROW: return N_SMAX;
      CVT_U_NARROW: return N_UMAX;
      default:      return ALL1;
    endcase
  endfunction

  // Largest magnitude a negative operand may have
  function automatic logic [XLEN-1:0] neg_limit(cvt_kind_e k);
    if (kind_unsigned(k)) return '0;
    return pos_limit(k) + XLEN'(1);
  endfunction

  function automatic logic [XLEN-1:0] pos_sat(cvt_kind_e k);
    if (kind_unsigned(k)) return ALL1;
    return kind_narrow(k) ? N_SMAX : W_SMAX;
  endfunction

  function automatic logic [XLEN-1:0] neg_sat(cvt_kind_e k);
    if (kind_unsigned(k)) return '0;
    return kind_narrow(k) ? N_SMIN : W_SMIN;
  endfunction

  logic over_range;

  always_comb begin
    over_range = evt_huge ||
                 (op_sign ? (mag > neg_limit(kind)) : (mag > pos_limit(kind)));
    sat_hit    = evt_nan || over_range;
    if (evt_nan)      sat_val = pos_sat(kind);
    else if (op_sign) sat_val = neg_sat(kind);
    else              sat_val = pos_sat(kind);
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32,
  localparam int FP_W    = 1 + EXP_W + MAN_W,
  localparam int UE_W    = EXP_W + 2
) (
  input  logic [FP_W-1:0] op_bits,
  input  logic            is_unsigned,
  input  logic            is_narrow,
  output logic [XLEN-1:0] result,
  output logic            invalid
);
  cvt_kind_e              kind;
  logic                   op_sign;
  logic signed [UE_W-1:0] exp_unb;
  logic [MAN_W:0]         sig;
  logic                   evt_nan;
  logic                   evt_inf;
  logic                   evt_tiny;
  logic                   evt_huge;
  logic                   sat_hit;
  logic [XLEN-1:0]        mag;
  logic [XLEN-1:0]        sat_val;
  logic [XLEN-1:0]        signed_val;

  assign kind = cvt_kind_e'({is_narrow, is_unsigned});

  f2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .op_bits (op_bits),
    .op_sign (op_sign),
    .exp_unb (exp_unb),
    .sig     (sig),
    .evt_nan (evt_nan),
    .evt_inf (evt_inf)
  );

  f2i_mag_shift #(.MAN_W(MAN_W), .EXP_W(EXP_W), .XLEN(XLEN)) u_shift (
    .sig      (sig),
    .exp_unb  (exp_unb),
    .mag      (mag),
    .evt_tiny (evt_tiny),
    .evt_huge (evt_huge)
  );

  f2i_sat_sel #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_sat (
    .kind     (kind),
    .op_sign  (op_sign),
    .evt_nan  (evt_nan),
    .evt_huge (evt_huge),
    .mag      (mag),
    .sat_hit  (sat_hit),
    .sat_val  (sat_val)
  );

  function automatic logic [XLEN-1:0] sext_narrow(logic [XLEN-1:0] v);
    return {{(XLEN-NARROW_W){v[NARROW_W-1]}}, v[NARROW_W-1:0]};
  endfunction

  always_comb begin
    signed_val = (op_sign && !kind_unsigned(kind)) ? (~mag + XLEN'(1)) : mag;
    if (sat_hit) begin
      result  = sat_val;
      invalid = 1'b1;
    end else begin
      result  = kind_narrow(kind) ? sext_narrow(signed_val) : signed_val;
      invalid = 1'b0;
    end
  end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32,
  parameter int FP_W     = 32
) (
  input logic [FP_W-1:0] op_bits,
  input logic            is_unsigned,
  input logic            is_narrow,
  input logic [XLEN-1:0] result,
  input logic            invalid,
  input logic            evt_nan,
  input logic            evt_tiny,
  input logic            evt_inf
);
  logic sgn;
  logic known;

  always_comb begin
    sgn   = op_bits[FP_W-1];
    known = !$isunknown({op_bits, is_unsigned, is_narrow, result, invalid});
    if (known) begin
      AST_TINY_ZERO: assert (!evt_tiny || (result == '0 && !invalid)) else $error("tiny operand"); // R2
      AST_NAN_FLAG: assert (!evt_nan || (invalid && result != '0 && !result[XLEN-1] == !is_unsigned)) else $error("nan"); // R5
      AST_UNS_NEG_ZERO: assert (!(is_unsigned && sgn && !evt_tiny && !evt_nan) || (result == '0 && invalid)) else $error("unsigned negative"); // R6
      AST_NARROW_SEXT: assert (!is_narrow || (result[XLEN-1:NARROW_W-1] == '0 || &result[XLEN-1:NARROW_W-1])) else $error("narrow extension"); // R8
      AST_SAT_SIGN: assert (!(invalid && !is_unsigned && !evt_nan) || (result[XLEN-1] == sgn)) else $error("signed saturation side"); // R3
      AST_INF_INVALID: assert (!evt_inf || invalid) else $error("infinity"); // R9
    end
  end
endmodule

bind f2i_conv f2i_conv_chk #(.XLEN(XLEN), .NARROW_W(NARROW_W), .FP_W(FP_W)) u_chk (
  .op_bits     (op_bits),
  .is_unsigned (is_unsigned),
  .is_narrow   (is_narrow),
  .result      (result),
  .invalid     (invalid),
  .evt_nan     (evt_nan),
  .evt_tiny    (evt_tiny),
  .evt_inf     (evt_inf)
);

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_bits = '0;
  logic        is_unsigned = 1'b0;
  logic        is_narrow = 1'b0;
  logic [63:0] result;
  logic        invalid;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  typedef struct {
    logic [63:0] exp_val;
    logic        exp_inv;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #2 clk = ~clk;

  f2i_conv dut (
    .op_bits     (op_bits),
    .is_unsigned (is_unsigned),
    .is_narrow   (is_narrow),
    .result      (result),
    .invalid     (invalid)
  );

  // Driver: one operand per clock, expected item pushed alongside
  task automatic drive(input logic [31:0] b, input logic u, input logic n,
                       input logic [63:0] ev, input logic ei, input string tag);
    item_t it;
    @(posedge clk);
    op_bits     = b;
    is_unsigned = u;
    is_narrow   = n;
    it.exp_val  = ev;
    it.exp_inv  = ei;
    it.tag      = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_tests++;
        if (result !== it.exp_val || invalid !== it.exp_inv) begin
          n_fail++;
          $display("FAIL %s: result=%h invalid=%b expected result=%h invalid=%b",
                   it.tag, result, invalid, it.exp_val, it.exp_inv);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // S=signed U=unsigned, N=narrow W=wide
    drive(32'h0000_0000, 0, 1, 64'h0, 0, "R2 +0 S32 idle value");
    drive(32'h3F80_0000, 0, 1, 64'h1, 0, "R1 1.0 S32");
    drive(32'h4030_0000, 0, 1, 64'h2, 0, "R1 2.75 S32");
    drive(32'hC030_0000, 0, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, "R1 -2.75 S32");
    drive(32'hC060_0000, 0, 0, 64'hFFFF_FFFF_FFFF_FFFD, 0, "R1 -3.5 S64");
    drive(32'h4E40_0000, 0, 1, 64'h3000_0000, 0, "R1 1.5*2^29 S32");
    drive(32'h3F7F_FFFF, 0, 1, 64'h0, 0, "R2 just below 1.0");
    drive(32'hBF00_0000, 1, 1, 64'h0, 0, "R2 -0.5 U32");
    drive(32'h0000_0001, 0, 0, 64'h0, 0, "R2 subnormal S64");
    drive(32'h8000_0000, 1, 0, 64'h0, 0, "R2 -0 U64");
    drive(32'h4EFF_FFFF, 0, 1, 64'h7FFF_FF80, 0, "R3 largest below 2^31");
    drive(32'h4F00_0000, 0, 1, 64'h7FFF_FFFF, 1, "R3 2^31 S32");
    drive(32'h5F00_0000, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 1, "R3 2^63 S64");
    drive(32'hCF00_0000, 0, 1, 64'hFFFF_FFFF_8000_0000, 0, "R4 exact -2^31");
    drive(32'hCF00_0001, 0, 1, 64'hFFFF_FFFF_8000_0000, 1, "R4 below -2^31");
    drive(32'hDF00_0000, 0, 0, 64'h8000_0000_0000_0000, 0, "R4 exact -2^63");
    drive(32'hDF80_0000, 0, 0, 64'h8000_0000_0000_0000, 1, "R4 -2^64 S64");
    drive(32'h7FC0_0000, 0, 1, 64'h7FFF_FFFF, 1, "R5 qNaN S32");
    drive(32'hFFC0_0000, 0, 1, 64'h7FFF_FFFF, 1, "R5 negative NaN S32");
    drive(32'h7F80_0001, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 1, "R5 sNaN S64");
    drive(32'hBF80_0000, 1, 1, 64'h0, 1, "R6 -1.0 U32");
    drive(32'hC030_0000, 1, 0, 64'h0, 1, "R6 -2.75 U64");
    drive(32'h7F80_0001, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R7 sNaN U64");
    drive(32'h7FC0_0000, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R7 NaN U32");
    drive(32'h4F80_0000, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R7 2^32 U32");
    drive(32'h5F80_0000, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R7 2^64 U64");
    drive(32'h4F32_D05E, 1, 1, 64'hFFFF_FFFF_B2D0_5E00, 0, "R8 3e9 U32 extension");
    drive(32'h4EFF_FFFF, 1, 1, 64'h7FFF_FF80, 0, "R8 bit31 clear U32");
    drive(32'h7F80_0000, 0, 1, 64'h7FFF_FFFF, 1, "R9 +inf S32");
    drive(32'hFF80_0000, 0, 0, 64'h8000_0000_0000_0000, 1, "R9 -inf S64");
    drive(32'h7F80_0000, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R9 +inf U32");
    drive(32'hFF80_0000, 1, 0, 64'h0, 1, "R9 R6 -inf U64");
    drive(32'h4F80_0000, 1, 0, 64'h0000_0001_0000_0000, 0, "R10 2^32 U64");
    drive(32'h5E80_0000, 0, 0, 64'h4000_0000_0000_0000, 0, "R10 2^62 S64");
    drive(32'h5F00_0000, 1, 0, 64'h8000_0000_0000_0000, 0, "R10 2^63 U64");
    drive(32'h5F7F_FFFF, 1, 0, 64'hFFFF_FF00_0000_0000, 0, "R10 largest below 2^64");
    @(posedge clk);
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: result=%h invalid=%b expected completion", result, invalid);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule